// File: doc/BRIEF.md
# Log2 Mantissa Approximator

This block returns the fractional part of the base-2 logarithm of a normalized mantissa v, where 1 ≤ v < 2. The caller supplies only the fraction bits x = v − 1 as a 14-bit unsigned word, so `in_x` carries the value in_x/2^14. The result log2(v) also lies in [0, 1) and comes out as a 16-bit unsigned fraction: `out_y` carries the value out_y/2^16. A floating-point unit or a fixed-point normalizer in front of this block supplies the exponent part of the logarithm. This block handles the mantissa only.

The result is formed as the product of two factors that are computed side by side. The first factor is the operand itself, because the parabolic coefficient of that factor is zero. The second factor is a second-degree curve. The top three operand bits select one of eight equal intervals. The lower eleven bits act as the position u inside that interval. For each interval, the curve uses a start value, a linear coefficient and a quadratic coefficient, all taken from synthesis-time tables. The curve is evaluated as (start + linear·u) − quadratic·u². The quantity u² comes from a dedicated squaring circuit, and every intermediate word is truncated. The `PIPE` parameter places zero or one register stage in front of the final multiplier.

Top module: `lg2_mant_approx`

## Requirements
- R1: For every one of the 16384 input codes, the output differs from log2(1 + in_x/2^14) by less than 2^-15, with `out_y` read as out_y/2^16.
- R2: An input code of 0 gives an output of exactly 0.
- R3: At the first code of each interval (in_x = i·2048 for i = 0..7, with the interval index in in_x[13:11]), the output equals floor(in_x · L_i / 2^18). Here L_i is h(i/8) rounded to 20 fractional bits, h(t) = log2(1+t)/t, and h(0) = 1/ln 2.
- R4: The output strictly increases from each input code to the next.
- R5: With `PIPE`=1, `out_valid` is `in_valid` delayed by one clock, and `out_y` carries the result for the operand that was accepted on that edge. With `PIPE`=0, `out_valid` follows `in_valid` with no delay, and `out_y` is the combinational result.
- R6: With `PIPE`=1, a clock edge on which `in_valid` is low leaves `out_y` unchanged, even when `in_x` changes.
- R7: With `PIPE`=1, a clock edge on which `rst_n` is low clears `out_valid`, even if `in_valid` is high. `out_valid` stays low after reset until an operand is accepted.
- R8: The pipelined and the unregistered variants give identical `out_y` for the same operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_x | input | 14 | Mantissa fraction, value in_x/2^14 |
| out_valid | output | 1 | Result qualifier |
| out_y | output | 16 | log2 fraction, value out_y/2^16 |

## Verification
A single wrong coefficient or a wrong shift in one interval shows up as an error larger than 2^-15 on that interval's codes. It appears on the output in the same cycle as the operand, or one cycle later when the register stage is present. The full sweep therefore pins a fault to its interval. A squarer fault only shows where the quadratic term weighs most, at mid-interval positions, and the sweep reaches those too. A stale or mistimed register stage shows as a one-cycle slip between the valid flag and the data, or as a result that changes on an idle edge. Both are visible on the first cycle after the stimulus.

// File: rtl/lg2_pkg.sv
// Shared constants for the log2 mantissa approximator: default widths,
// binary-point positions and the per-interval coefficient tables.
// Assumes eight intervals. Tables are listed from interval 0 upward.
package lg2_pkg;

    localparam int X_W_D   = 14;  // operand fraction bits
    localparam int IDX_W_D = 3;   // interval index bits
    localparam int OUT_W_D = 16;  // result fraction bits
    localparam int SQ_W_D  = 16;  // kept bits of the local square
    localparam int L_F_D   = 20;  // fraction bits of start values and of s2
    localparam int J_W_D   = 16;  // signed linear coefficient width
    localparam int J_LSB_D = 18;  // linear coefficient lsb weight 2^-18
    localparam int C_W_D   = 12;  // signed quadratic coefficient width
    localparam int C_LSB_D = 18;  // quadratic coefficient lsb weight 2^-18

    localparam int N_INT_D = 1 << IDX_W_D;
    localparam int L_W_D   = L_F_D + 1;

    // start value of the help function per interval, 1.20 unsigned
    localparam logic [L_W_D-1:0] L_TAB_D [N_INT_D] = '{
        21'd1512775, 21'd1425434, 21'd1350264, 21'd1284664,
        21'd1226755, 21'd1175143, 21'd1128764, 21'd1086793
    };

    // linear coefficient (slope plus quadratic term), lsb 2^-18
    localparam logic signed [J_W_D-1:0] J_TAB_D [N_INT_D] = '{
        -16'sd23557, -16'sd20131, -16'sd17465, -16'sd15342,
        -16'sd13617, -16'sd12193, -16'sd10999, -16'sd9988
    };

    // quadratic coefficient (midpoint fit), lsb 2^-18
    localparam logic signed [C_W_D-1:0] C_TAB_D [N_INT_D] = '{
        -12'sd1722, -12'sd1338, -12'sd1065, -12'sd865,
        -12'sd714,  -12'sd598,  -12'sd507,  -12'sd434
    };

    // right shift that moves a value from one binary point to another
    function automatic int align_shift(input int from_frac, input int to_frac);
        return from_frac - to_frac;
    endfunction

endpackage

// File: rtl/lg2_square.sv
// Dedicated squarer for the interval-local fraction.
// Generates each diagonal partial product once and each cross product once
// (doubled by position), instead of a full array multiplier.
// Keeps the SQ_W most significant bits of the square, truncated.
// Assumes SQ_W <= 2*XW_W.
module lg2_square #(
    parameter int XW_W = 11,
    parameter int SQ_W = 16
) (
    input  logic [XW_W-1:0] xw_i,
    output logic [SQ_W-1:0] sq_o
);
    localparam int FW = 2 * XW_W;

    logic [FW-1:0] acc;

    // sum the folded partial products of xw*xw
    always_comb begin
        acc = '0;
        for (int i = 0; i < XW_W; i++) begin
            if (xw_i[i]) acc = acc + (FW'(1) << (2 * i));
            for (int k = i + 1; k < XW_W; k++) begin
                if (xw_i[i] && xw_i[k]) acc = acc + (FW'(1) << (i + k + 1));
            end
        end
    end

    assign sq_o = acc[FW-1 -: SQ_W];

    // a fraction below one never grows when squared
    always_comb begin
        // R1
        sq_le_x_chk: assert (acc <= {xw_i, {XW_W{1'b0}}});
    end

endmodule

// File: rtl/lg2_coef_sel.sv
// Coefficient selection: picks the start value, linear and quadratic
// coefficient of the interval addressed by the operand's top bits.
// Built as a one-hot decoded AND-OR mux per table. Tables are synthesis-time.
module lg2_coef_sel #(
    parameter int IDX_W = 3,
    parameter int L_W   = 21,
    parameter int J_W   = 16,
    parameter int C_W   = 12,
    parameter logic        [L_W-1:0] L_TAB [1<<IDX_W] = lg2_pkg::L_TAB_D,
    parameter logic signed [J_W-1:0] J_TAB [1<<IDX_W] = lg2_pkg::J_TAB_D,
    parameter logic signed [C_W-1:0] C_TAB [1<<IDX_W] = lg2_pkg::C_TAB_D
) (
    input  logic [IDX_W-1:0]        idx_i,
    output logic [L_W-1:0]          l_o,
    output logic signed [J_W-1:0]   j_o,
    output logic signed [C_W-1:0]   c_o
);
    localparam int N_INT = 1 << IDX_W;

    logic [N_INT-1:0]           hit;
    logic [L_W-1:0]             l_term [N_INT];
    logic [J_W-1:0]             j_term [N_INT];
    logic [C_W-1:0]             c_term [N_INT];

    // one decoded select line and one gated table row per interval
    for (genvar g = 0; g < N_INT; g++) begin : g_row
        assign hit[g]    = (idx_i == IDX_W'(g));
        assign l_term[g] = hit[g] ? L_TAB[g] : '0;
        assign j_term[g] = hit[g] ? J_TAB[g] : '0;
        assign c_term[g] = hit[g] ? C_TAB[g] : '0;
    end

    // OR the gated rows together
    always_comb begin
        l_o = '0;
        j_o = '0;
        c_o = '0;
        for (int n = 0; n < N_INT; n++) begin
            l_o = l_o | l_term[n];
            j_o = j_o | $signed(j_term[n]);
            c_o = c_o | $signed(c_term[n]);
        end
    end

    // exactly one row selected for any index
    always_comb begin
        // R3
        one_row_chk: assert ($countones(hit) == 1);
    end

endmodule

// File: rtl/lg2_interp.sv
// Second factor: within one interval evaluates (l + j*u) - c*u^2.
// u is the local fraction and u^2 comes from the squarer. Every product
// is brought to the L_F binary point by an arithmetic right shift
// (truncation toward minus infinity). Assumes the result is positive
// and below 2.0, which the coefficient tables guarantee.
module lg2_interp #(
    parameter int XW_W  = 11,
    parameter int SQ_W  = 16,
    parameter int L_F   = 20,
    parameter int J_W   = 16,
    parameter int J_LSB = 18,
    parameter int C_W   = 12,
    parameter int C_LSB = 18
) (
    input  logic [L_F:0]            l_i,
    input  logic signed [J_W-1:0]   j_i,
    input  logic signed [C_W-1:0]   c_i,
    input  logic [XW_W-1:0]         xw_i,
    input  logic [SQ_W-1:0]         sq_i,
    output logic [L_F:0]            s2_o
);
    localparam int L_W    = L_F + 1;
    localparam int SUM_W  = L_W + 2;
    localparam int JP_W   = J_W + XW_W + 1;
    localparam int CP_W   = C_W + SQ_W + 1;
    localparam int JX_SH  = lg2_pkg::align_shift(J_LSB + XW_W, L_F);
    localparam int CQ_SH  = lg2_pkg::align_shift(C_LSB + SQ_W, L_F);
    localparam logic [L_W-1:0] S2_LO = L_W'((1 << L_F) - (1 << (L_F - 10)));
    localparam logic [L_W-1:0] S2_HI = L_W'(3 << (L_F - 1));

    logic signed [JP_W-1:0]  jx_full;
    logic signed [CP_W-1:0]  cq_full;
    logic signed [SUM_W-1:0] jx_al;
    logic signed [SUM_W-1:0] cq_al;
    logic signed [SUM_W-1:0] sum_lin;
    logic signed [SUM_W-1:0] s2_full;

    // linear branch: coefficient times local fraction, aligned
    always_comb begin
        jx_full = JP_W'(j_i) * $signed({1'b0, xw_i});
        jx_al   = SUM_W'(jx_full >>> JX_SH);
    end

    // quadratic branch: coefficient times local square, aligned
    always_comb begin
        cq_full = CP_W'(c_i) * $signed({1'b0, sq_i});
        cq_al   = SUM_W'(cq_full >>> CQ_SH);
    end

    // fixed order: add the linear term first, then take off the quadratic
    always_comb begin
        sum_lin = $signed({2'b00, l_i}) + jx_al;
        s2_full = sum_lin - cq_al;
    end

    assign s2_o = s2_full[L_W-1:0];

    // the help function stays between 1 and 1/ln2 on the whole range
    always_comb begin
        // R1
        s2_range_chk: assert (s2_full[SUM_W-1:L_W] == '0 && s2_o >= S2_LO && s2_o <= S2_HI);
    end

endmodule

// File: rtl/lg2_mant_approx.sv
// Log2 mantissa approximator. Operand in_x is the fraction of a
// mantissa in [1,2). The result is the fraction of its base-2 logarithm,
// computed as s1*s2. s1 is the operand itself (parabolic coefficient 0).
// s2 is an interval-indexed second-degree curve. PIPE selects zero or
// one register stage ahead of the final multiplier. Synchronous
// active-low reset clears the valid stage only.
module lg2_mant_approx #(
    parameter int X_W   = lg2_pkg::X_W_D,
    parameter int IDX_W = lg2_pkg::IDX_W_D,
    parameter int OUT_W = lg2_pkg::OUT_W_D,
    parameter int SQ_W  = lg2_pkg::SQ_W_D,
    parameter int L_F   = lg2_pkg::L_F_D,
    parameter int J_W   = lg2_pkg::J_W_D,
    parameter int J_LSB = lg2_pkg::J_LSB_D,
    parameter int C_W   = lg2_pkg::C_W_D,
    parameter int C_LSB = lg2_pkg::C_LSB_D,
    parameter int PIPE  = 1,
    parameter logic        [L_F:0]   L_TAB [1<<IDX_W] = lg2_pkg::L_TAB_D,
    parameter logic signed [J_W-1:0] J_TAB [1<<IDX_W] = lg2_pkg::J_TAB_D,
    parameter logic signed [C_W-1:0] C_TAB [1<<IDX_W] = lg2_pkg::C_TAB_D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [X_W-1:0]    in_x,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_y
);
    localparam int XW_W = X_W - IDX_W;
    localparam int L_W  = L_F + 1;
    localparam int P_W  = X_W + L_W;
    localparam int P_SH = lg2_pkg::align_shift(X_W + L_F, OUT_W);

    logic [IDX_W-1:0]        idx;
    logic [XW_W-1:0]         xw;
    logic [SQ_W-1:0]         sq;
    logic [L_W-1:0]          l_sel;
    logic signed [J_W-1:0]   j_sel;
    logic signed [C_W-1:0]   c_sel;
    logic [L_W-1:0]          s2;
    logic [X_W-1:0]          s1;
    logic [X_W-1:0]          s1_m;
    logic [L_W-1:0]          s2_m;
    logic [P_W-1:0]          prod;

    // split the operand into interval index and local fraction
    assign idx = in_x[X_W-1 -: IDX_W];
    assign xw  = in_x[XW_W-1:0];

    // first factor: parabolic term with zero coefficient reduces to x
    assign s1 = in_x;

    lg2_square #(
        .XW_W (XW_W),
        .SQ_W (SQ_W)
    ) u_square (
        .xw_i (xw),
        .sq_o (sq)
    );

    lg2_coef_sel #(
        .IDX_W (IDX_W),
        .L_W   (L_W),
        .J_W   (J_W),
        .C_W   (C_W),
        .L_TAB (L_TAB),
        .J_TAB (J_TAB),
        .C_TAB (C_TAB)
    ) u_coef (
        .idx_i (idx),
        .l_o   (l_sel),
        .j_o   (j_sel),
        .c_o   (c_sel)
    );

    lg2_interp #(
        .XW_W  (XW_W),
        .SQ_W  (SQ_W),
        .L_F   (L_F),
        .J_W   (J_W),
        .J_LSB (J_LSB),
        .C_W   (C_W),
        .C_LSB (C_LSB)
    ) u_interp (
        .l_i  (l_sel),
        .j_i  (j_sel),
        .c_i  (c_sel),
        .xw_i (xw),
        .sq_i (sq),
        .s2_o (s2)
    );

    if (PIPE != 0) begin : g_reg
        logic              v_q;
        logic [X_W-1:0]    s1_q;
        logic [L_W-1:0]    s2_q;

        // valid stage, cleared by reset
        always_ff @(posedge clk) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= in_valid;
        end

        // factor stage, loaded only for accepted operands
        always_ff @(posedge clk) begin
            if (in_valid) begin
                s1_q <= s1;
                s2_q <= s2;
            end
        end

        assign s1_m      = s1_q;
        assign s2_m      = s2_q;
        assign out_valid = v_q;

        // R5
        vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R5
        vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R6
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_y));
        // R2
        zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_x == '0) |=> out_y == '0);
    end else begin : g_comb
        assign s1_m      = s1;
        assign s2_m      = s2;
        assign out_valid = in_valid;

        // R2
        zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_x == '0) |-> out_y == '0);
    end

    // final multiplier and truncation to the output fraction
    assign prod  = P_W'(s1_m) * P_W'(s2_m);
    assign out_y = prod[P_SH +: OUT_W];

    // R1
    int_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> prod[P_W-1:P_SH+OUT_W] == '0);

endmodule

// File: tb/lg2_mant_approx_tb.sv
module lg2_mant_approx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_x = '0;
    logic        pv, cv;
    logic [15:0] py, cy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lg2_mant_approx #(.PIPE(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(pv), .out_y(py)
    );

    lg2_mant_approx #(.PIPE(0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
        .out_valid(cv), .out_y(cy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic real ref_log2(input int x);
        return $ln(1.0 + x / 16384.0) / $ln(2.0);
    endfunction

    function automatic longint start_coef(input int i);
        real t, h;
        t = i / 8.0;
        if (i == 0) h = 1.0 / $ln(2.0);
        else        h = ($ln(1.0 + t) / $ln(2.0)) / t;
        return longint'($rtoi(h * 1048576.0 + 0.5));
    endfunction

    // drive one operand; comb result read same cycle, pipe result after edge
    task automatic apply(input int x, input bit v, output logic [15:0] yc,
                         output logic [15:0] yp, output logic vp);
        @(negedge clk);
        in_valid = v;
        in_x     = 14'(x);
        #1;
        yc = cy;
        @(posedge clk);
        #1;
        yp = py;
        vp = pv;
    endtask

    task automatic t_reset_state();
        // R7: valid low after reset, before any operand
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(pv == 1'b0, "R7", "valid after reset", pv, 0);
    endtask

    task automatic t_zero();
        logic [15:0] yc, yp;
        logic vp;
        apply(0, 1'b1, yc, yp, vp);
        chk(yc == 16'd0, "R2", "zero comb", yc, 0);
        chk(yp == 16'd0, "R2", "zero pipe", yp, 0);
    endtask

    task automatic t_interval_starts();
        logic [15:0] yc, yp;
        logic vp;
        for (int i = 0; i < 8; i++) begin
            longint exp;
            exp = (longint'(i * 2048) * start_coef(i)) >> 18;
            apply(i * 2048, 1'b1, yc, yp, vp);
            chk(longint'(yc) == exp, "R3", "interval start", yc, exp);
        end
    endtask

    task automatic t_sweep();
        logic [15:0] yc, yp;
        logic vp;
        longint prev;
        real worst;
        int bad1, bad4, bad8;
        prev  = -1;
        worst = 0.0;
        bad1  = 0;
        bad4  = 0;
        bad8  = 0;
        for (int x = 0; x < 16384; x++) begin
            real err;
            apply(x, 1'b1, yc, yp, vp);
            err = yc / 65536.0 - ref_log2(x);
            if (err < 0.0) err = -err;
            if (err > worst) worst = err;
            if (err >= 1.0 / 32768.0 && bad1 < 4) begin
                bad1++;
                chk(1'b0, "R1", "accuracy", yc, longint'($rtoi(ref_log2(x) * 65536.0)));
            end
            if (longint'(yc) <= prev && bad4 < 4) begin
                bad4++;
                chk(1'b0, "R4", "not increasing", yc, prev + 1);
            end
            if (yp !== yc && bad8 < 4) begin
                bad8++;
                chk(1'b0, "R8", "pipe vs comb", yp, yc);
            end
            prev = longint'(yc);
        end
        chk(bad1 == 0, "R1", "sweep accuracy", bad1, 0);
        chk(bad4 == 0, "R4", "sweep monotonic", bad4, 0);
        chk(bad8 == 0, "R8", "sweep variants", bad8, 0);
        $display("sweep worst abs error = %e", worst);
    endtask

    task automatic t_valid_latency();
        logic [15:0] yc, yp, y_hold;
        logic vp;
        apply(0, 1'b0, yc, yp, vp);
        chk(vp == 1'b0, "R5", "pipe valid idle", vp, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = 14'd5000;
        #1;
        chk(cv == 1'b1, "R5", "comb valid same cycle", cv, 1);
        yc = cy;
        chk(pv == 1'b0, "R5", "pipe valid before edge", pv, 0);
        @(posedge clk);
        #1;
        chk(pv == 1'b1, "R5", "pipe valid after edge", pv, 1);
        chk(py == yc, "R5", "pipe data aligned", py, yc);
        y_hold = py;
        // R6: idle edge with a new operand must not change the result
        @(negedge clk);
        in_valid = 1'b0;
        in_x     = 14'd12000;
        #1;
        chk(cv == 1'b0, "R5", "comb valid drop", cv, 0);
        @(posedge clk);
        #1;
        chk(pv == 1'b0, "R5", "pipe valid drop", pv, 0);
        chk(py == y_hold, "R6", "hold on idle edge", py, y_hold);
        @(posedge clk);
        #1;
        chk(py == y_hold, "R6", "hold second idle edge", py, y_hold);
    endtask

    task automatic t_reset_flush();
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = 14'd777;
        rst_n    = 1'b0;
        @(posedge clk);
        #1;
        chk(pv == 1'b0, "R7", "reset beats valid", pv, 0);
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(pv == 1'b0, "R7", "valid low after release", pv, 0);
    endtask

    initial begin
        t_reset_state();
        t_zero();
        t_interval_starts();
        t_valid_latency();
        t_reset_flush();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule